// File: doc/BRIEF.md
# Static Link Chain Walker

This unit resolves the base address of an enclosing activation record a given number of lexical levels outward from the current one. Every activation record keeps its static link in the word directly above its base. The walker starts from the current base pointer and follows that link once per level. On each step it reads the stack word at `pointer + 1`, and the value read becomes the new pointer.

A client pulses `start` together with a level count and the current base pointer. The walker drives a read port into stack memory that has a combinational read path and performs exactly one read per level. The first read is issued in the start cycle itself. When the walk finishes, the walker returns the final base with a one-cycle `done` strobe. A level count beyond the supported nesting depth, or a link address beyond the last stack word, ends the walk with `err` set and no result.

Top module: `static_link_walker`

## Requirements
- R1: After reset `done`, `err`, `busy` and `memRdEn` are low and `result` is zero.
- R2: A start with level count 0 performs no memory read and returns `curBase` unchanged, with `done` high (and `err` low) in the cycle after start.
- R3: For a level count L of 1 to 3, the walker issues exactly L reads. Each read is at address `pointer + 1`, where the pointer starts at `curBase` and becomes the word just read. The last word read is returned on `result`.
- R4: For L of 1 to 3, `done` is high exactly L cycles after the start cycle. The first read happens in the start cycle.
- R5: `busy` is high from the cycle after an accepted multi-level start until the cycle in which `done` is high, where it is low. `busy` and `done` are never high together. A start received while `busy` is high is ignored and produces no read and no `done`.
- R6: A level count above 3 (up to the 3-bit maximum of 7) ends the walk in the cycle after start with `done` and `err` high, `result` zero and no memory read.
- R7: If a link address `pointer + 1` would exceed 39 (the last of 40 stack words), that read is not issued. `done` and `err` rise in the next cycle, `result` is zero, and the reads before it still count, so `done` appears k cycles after start when step k fails.
- R8: Each accepted start yields exactly one single-cycle `done` pulse. `err` is high only together with `done`.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous reset, active low |
| start | input | 1 | Request pulse; accepted only while not busy |
| levels | input | 3 | Number of lexical levels to walk |
| curBase | input | 16 | Base pointer of the current activation record |
| memRdEn | output | 1 | Stack read strobe |
| memRdAddr | output | 6 | Stack read address (link word) |
| memRdData | input | 16 | Stack word at `memRdAddr`, same cycle |
| done | output | 1 | One-cycle completion strobe |
| result | output | 16 | Resolved base address, zero on error |
| err | output | 1 | Walk ended on a bad level count or address |
| busy | output | 1 | Multi-level walk in progress |

## Verification
The hardest situation to reach is a link address that leaves the stack partway through a walk, after some valid reads have already been made. The bench loads the stack with one well-formed chain of records and one record whose stored link points near the top of memory. A two- or three-level walk through that record then fails on its second step, which tests both the early `done` timing and the count of reads issued before the failure. A second hard case is a start that arrives while the walker is busy. The bench raises a zero-level start one cycle into a three-level walk and checks that no extra completion or read appears.

// File: rtl/slw_pkg.sv
package slw_pkg;
  typedef struct packed {
    logic rdEn;    // issue a link read this cycle
    logic finish;  // walk ends at this edge
    logic fault;   // walk ends with error
  } walkStrobe_t;
endpackage

// File: rtl/slw_ctrl.sv
module slw_ctrl
  import slw_pkg::*;
#(
  parameter int MAX_LVL = 3,
  parameter int LVL_W   = 3,
  localparam int CNT_W  = $clog2(MAX_LVL + 1)
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             start,
  input  logic [LVL_W-1:0] levels,
  input  logic             addrOk,
  output walkStrobe_t      stb,
  output logic             busy
);
  logic             busyQ, busyD;
  logic [CNT_W-1:0] cntQ, cntD;

  always_comb begin
    stb   = '0;
    busyD = busyQ;
    cntD  = cntQ;
    if (!busyQ) begin
      if (start) begin
        if (levels > LVL_W'(MAX_LVL)) begin
          stb.finish = 1'b1;
          stb.fault  = 1'b1;
        end else if (levels == '0) begin
          stb.finish = 1'b1;
        end else if (!addrOk) begin
          stb.finish = 1'b1;
          stb.fault  = 1'b1;
        end else begin
          stb.rdEn = 1'b1;
          if (levels == LVL_W'(1)) begin
            stb.finish = 1'b1;
          end else begin
            busyD = 1'b1;
            cntD  = CNT_W'(levels - LVL_W'(1));
          end
        end
      end
    end else begin
      if (!addrOk) begin
        stb.finish = 1'b1;
        stb.fault  = 1'b1;
        busyD      = 1'b0;
      end else begin
        stb.rdEn = 1'b1;
        if (cntQ == CNT_W'(1)) begin
          stb.finish = 1'b1;
          busyD      = 1'b0;
        end else begin
          cntD = cntQ - CNT_W'(1);
        end
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      busyQ <= 1'b0;
      cntQ  <= '0;
    end else begin
      busyQ <= busyD;
      cntQ  <= cntD;
    end
  end

  assign busy = busyQ;

  // R4
  busy_count_chk: assert property (@(posedge clk) disable iff (!rst_n)
    busyQ |-> (cntQ != '0 && cntQ < CNT_W'(MAX_LVL)));

  // R5
  busy_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (busyQ && !stb.finish) |=> busyQ);
endmodule

// File: rtl/slw_datapath.sv
module slw_datapath
  import slw_pkg::*;
#(
  parameter int DATA_W = 16,
  parameter int DEPTH  = 40,
  localparam int ADDR_W = $clog2(DEPTH)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  walkStrobe_t       stb,
  input  logic              walking,
  input  logic [DATA_W-1:0] curBase,
  input  logic [DATA_W-1:0] memRdData,
  output logic              addrOk,
  output logic              memRdEn,
  output logic [ADDR_W-1:0] memRdAddr,
  output logic [DATA_W-1:0] result,
  output logic              done,
  output logic              err
);
  localparam logic [DATA_W:0] LAST_ADDR = (DATA_W + 1)'(DEPTH - 1);

  logic [DATA_W-1:0] ptrQ, srcPtr;
  logic [DATA_W:0]   linkAddr;
  logic [DATA_W-1:0] resultQ;
  logic              doneQ, errQ;

  assign srcPtr    = walking ? ptrQ : curBase;
  assign linkAddr  = {1'b0, srcPtr} + (DATA_W + 1)'(1);
  assign addrOk    = (linkAddr <= LAST_ADDR);
  assign memRdAddr = linkAddr[ADDR_W-1:0];
  assign memRdEn   = stb.rdEn;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ptrQ    <= '0;
      resultQ <= '0;
      doneQ   <= 1'b0;
      errQ    <= 1'b0;
    end else begin
      if (stb.rdEn) ptrQ <= memRdData;
      doneQ <= stb.finish;
      errQ  <= stb.finish & stb.fault;
      if (stb.finish) begin
        if (stb.fault)     resultQ <= '0;
        else if (stb.rdEn) resultQ <= memRdData;
        else               resultQ <= curBase;
      end
    end
  end

  assign result = resultQ;
  assign done   = doneQ;
  assign err    = errQ;

  // R7
  rd_range_chk: assert property (@(posedge clk) disable iff (!rst_n)
    memRdEn |-> (memRdAddr <= ADDR_W'(DEPTH - 1)));

  // R8
  err_with_done_chk: assert property (@(posedge clk) disable iff (!rst_n)
    err |-> done);
endmodule

// File: rtl/static_link_walker.sv
module static_link_walker
  import slw_pkg::*;
#(
  parameter int DATA_W  = 16,
  parameter int DEPTH   = 40,
  parameter int MAX_LVL = 3,
  parameter int LVL_W   = 3,
  localparam int ADDR_W = $clog2(DEPTH)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              start,
  input  logic [LVL_W-1:0]  levels,
  input  logic [DATA_W-1:0] curBase,
  output logic              memRdEn,
  output logic [ADDR_W-1:0] memRdAddr,
  input  logic [DATA_W-1:0] memRdData,
  output logic              done,
  output logic [DATA_W-1:0] result,
  output logic              err,
  output logic              busy
);
  walkStrobe_t stb;
  logic        addrOk;

  slw_ctrl #(.MAX_LVL(MAX_LVL), .LVL_W(LVL_W)) u_ctrl (
    .clk(clk), .rst_n(rst_n), .start(start), .levels(levels),
    .addrOk(addrOk), .stb(stb), .busy(busy)
  );

  slw_datapath #(.DATA_W(DATA_W), .DEPTH(DEPTH)) u_dp (
    .clk(clk), .rst_n(rst_n), .stb(stb), .walking(busy),
    .curBase(curBase), .memRdData(memRdData), .addrOk(addrOk),
    .memRdEn(memRdEn), .memRdAddr(memRdAddr), .result(result),
    .done(done), .err(err)
  );

  // R2
  zero_level_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (start && !busy && levels == '0) |=>
      (done && !err && result == $past(curBase)));

  // R6
  bad_level_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (start && !busy && levels > LVL_W'(MAX_LVL)) |=> (done && err && result == '0));

  // R5
  busy_no_done_chk: assert property (@(posedge clk) disable iff (!rst_n)
    busy |-> !done);
endmodule

// File: tb/sim_static_link_walker.sv
module sim_static_link_walker;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        start = 1'b0;
  logic [2:0]  levels = '0;
  logic [15:0] curBase = '0;
  logic        memRdEn;
  logic [5:0]  memRdAddr;
  logic [15:0] memRdData;
  logic        done;
  logic [15:0] result;
  logic        err;
  logic        busy;

  int tests = 0;
  int fails = 0;
  int cycle = 0;
  int rdCnt = 0;

  logic [15:0] mem [40];

  typedef struct {
    int    res;
    bit    isErr;
    int    doneCyc;
    int    reads;
    string tag;
  } exp_t;
  exp_t expQ[$];

  always #2 clk = ~clk;
  always @(posedge clk) cycle <= cycle + 1;

  assign memRdData = (memRdAddr < 6'd40) ? mem[memRdAddr] : 16'hDEAD;

  static_link_walker u0 (
    .clk(clk), .rst_n(rst_n), .start(start), .levels(levels),
    .curBase(curBase), .memRdEn(memRdEn), .memRdAddr(memRdAddr),
    .memRdData(memRdData), .done(done), .result(result), .err(err),
    .busy(busy)
  );

  task automatic check(bit ok, string tag, string what, int act, int expv);
    tests++;
    if (!ok) begin
      fails++;
      $display("FAIL %s %s: actual %0d expected %0d", tag, what, act, expv);
    end
  endtask

  // monitor: pops expected items on done
  always @(negedge clk) begin
    if (rst_n) begin
      if (done) begin
        if (expQ.size() == 0) begin
          check(1'b0, "R8", "unexpected done", 1, 0);
        end else begin
          exp_t e;
          e = expQ.pop_front();
          check(int'(result) == e.res, e.tag, "result", int'(result), e.res);
          check(err == e.isErr, e.tag, "err", int'(err), int'(e.isErr));
          check(cycle == e.doneCyc, e.tag, "done cycle", cycle, e.doneCyc);
          check(rdCnt == e.reads, e.tag, "read count", rdCnt, e.reads);
        end
        rdCnt = 0;
      end else if (memRdEn) begin
        rdCnt++;
        check(memRdAddr <= 6'd39, "R7", "read address", int'(memRdAddr), 39);
      end
    end
  end

  function automatic exp_t model(int lv, int base, string tag, int startCyc);
    exp_t e;
    int ptr;
    e.tag = tag;
    e.reads = 0;
    e.isErr = 0;
    if (lv > 3) begin
      e.res = 0; e.isErr = 1; e.doneCyc = startCyc + 1;
      return e;
    end
    ptr = base;
    for (int k = 1; k <= lv; k++) begin
      if (ptr + 1 > 39) begin
        e.res = 0; e.isErr = 1; e.doneCyc = startCyc + k;
        return e;
      end
      ptr = int'(mem[ptr + 1]);
      e.reads++;
    end
    e.res = ptr;
    e.doneCyc = startCyc + ((lv == 0) ? 1 : lv);
    return e;
  endfunction

  task automatic waitEmpty();
    while (expQ.size() != 0) @(negedge clk);
    @(posedge clk); #1;
  endtask

  task automatic runWalk(int lv, int base, string tag);
    @(posedge clk); #1;
    expQ.push_back(model(lv, base, tag, cycle));
    start = 1'b1; levels = 3'(lv); curBase = 16'(base);
    @(posedge clk); #1;
    start = 1'b0;
    waitEmpty();
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    fails++;
    $display("FAIL watchdog: actual hung expected finish");
    $display("  [TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end

  initial begin
    for (int i = 0; i < 40; i++) mem[i] = 16'(i * 3 + 7);
    // chain 20 -> 12 -> 5 -> 1 -> 0
    mem[21] = 16'd12; mem[13] = 16'd5; mem[6] = 16'd1; mem[2] = 16'd0;
    // record 30 links to 45: next link address 46 is outside the stack
    mem[31] = 16'd45;
    repeat (3) @(posedge clk);
    #1;
    // R1 reset state
    check(!done, "R1", "done", int'(done), 0);
    check(!err, "R1", "err", int'(err), 0);
    check(!busy, "R1", "busy", int'(busy), 0);
    check(!memRdEn, "R1", "memRdEn", int'(memRdEn), 0);
    check(result == 0, "R1", "result", int'(result), 0);
    rst_n = 1'b1;

    runWalk(0, 20, "R2");
    runWalk(0, 39, "R2");
    runWalk(1, 20, "R3");
    runWalk(2, 20, "R4");
    runWalk(3, 20, "R4");
    runWalk(3, 12, "R3");
    runWalk(4, 20, "R6");
    runWalk(7, 5, "R6");
    runWalk(1, 39, "R7");
    runWalk(2, 30, "R7");
    runWalk(3, 30, "R7");

    // R5: busy across walk and start ignored while busy
    @(posedge clk); #1;
    expQ.push_back(model(3, 20, "R5", cycle));
    start = 1'b1; levels = 3'd3; curBase = 16'd20;
    @(posedge clk); #1;
    levels = 3'd0; curBase = 16'd9;
    @(negedge clk);
    check(busy, "R5", "busy step2", int'(busy), 1);
    @(posedge clk); #1;
    start = 1'b0;
    @(negedge clk);
    check(busy, "R5", "busy step3", int'(busy), 1);
    @(posedge clk); #1;
    check(!busy, "R5", "busy at done", int'(busy), 0);
    check(done, "R5", "done", int'(done), 1);
    repeat (3) @(negedge clk);
    check(expQ.size() == 0, "R5", "pending", expQ.size(), 0);
    check(!done, "R8", "extra done", int'(done), 0);

    runWalk(2, 12, "R3");

    $display("  [TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end
endmodule